// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps the sharer record for a small set of coherence directory entries. Each entry names its sharers with a few node-ID pointers rather than one bit per node. A read request from a node records that node as a sharer. A write request returns the set of nodes whose copies must be invalidated, as a bit mask with one bit per node. The entry is then left holding only the writer.

When a read arrives and every pointer is already in use, the entry overflows under the policy given with that request. Under broadcast, the entry gives up exact tracking, and its next write invalidates every node. Under replacement, one pointer is reused in round-robin order and the displaced node is reported for invalidation at once. Under coarse grouping, the entry switches to a vector with one bit per group of nodes, and a write invalidates every node in each marked group.

Each entry is a three-state machine. ST_IDLE means no sharers. ST_EXACT means the sharers are held as pointers. ST_OVERFLOW means the sharers are held as a group vector; broadcast is a group vector with every bit set. The transitions are:
- IDLE to EXACT, on the first read or on any write.
- EXACT to EXACT, on a repeat read, on a fill of a free pointer, on a replacement, or on a write.
- EXACT to OVERFLOW, on a read that overflows under broadcast or coarse grouping.
- OVERFLOW to OVERFLOW, on a read, which marks that reader's group.
- OVERFLOW to EXACT, on a write.

Top module: `dir_lptr_top`

## Requirements
- R1: After reset every entry is idle and inv_valid and inv_mask are 0. A write to an idle entry reports inv_valid=1 with an all-zero mask.
- R2: inv_valid and inv_mask are registered. They reflect the request sampled at the previous rising edge, and inv_valid is 0 after a cycle with no request. Every write reports inv_valid=1. A read that takes a free pointer reports inv_valid=0.
- R3: A read from a node that a valid pointer already names leaves the entry unchanged, as the mask of the next write shows.
- R4: While an entry is exact, a write invalidates exactly the nodes named by its valid pointers, with the writer's own bit always 0. Afterwards the entry holds only the writer, so the next write by another node invalidates only the previous writer.
- R5: policy encoding: 2'b00 selects broadcast, 2'b01 replacement, 2'b10 coarse grouping, and 2'b11 acts as broadcast. The policy is applied only to a read that finds every pointer full.
- R6: Under broadcast, an overflowing read reports nothing. The next write invalidates all nodes except the writer.
- R7: Under replacement, an overflowing read stores the new node in the pointer slot chosen by the entry's round-robin index. It reports inv_valid=1 with only the displaced node's bit set.
- R8: The round-robin index starts at slot 0 after reset and after each write, and advances by one slot on each replacement, wrapping after the last slot.
- R9: Under coarse grouping, node n belongs to group n/GRP. An overflowing read marks the groups of every pointer and of the new reader. The next write invalidates every node in a marked group except the writer.
- R10: A read to an entry in overflow marks the reader's group.
- R11: Entries are independent. A request changes only the entry selected by req_entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_entry | input | ENT_W | Index of the directory entry |
| req_node | input | NID_W | Node making the request |
| policy | input | 2 | Overflow policy for this request |
| inv_valid | output | 1 | Invalidation report is valid |
| inv_mask | output | NODES | Nodes to invalidate, one bit per node |

## Verification
The bench builds the block with 16 nodes, 2 pointers per entry, groups of 2 nodes and 4 entries. With these values the third distinct reader of an entry overflows it, and the group vector is 8 bits wide. Each of the four entries can hold a different policy in the same run, which also exercises their independence. Two pointers let two successive replacements show the round-robin index wrap, and odd and even readers show group membership.

// File: rtl/dirlp_pkg.sv
package dirlp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_EXACT    = 2'd1,
        ST_OVERFLOW = 2'd2
    } ent_state_t;

    typedef enum logic [1:0] {
        POL_BCAST   = 2'b00,
        POL_REPLACE = 2'b01,
        POL_COARSE  = 2'b10,
        POL_ALT     = 2'b11
    } ovf_policy_t;

endpackage

// File: rtl/cvec_expand.sv
module cvec_expand #(
    parameter int NODES = 16,
    parameter int GRP   = 2,
    localparam int CV_W = (NODES + GRP - 1) / GRP
) (
    input  logic [CV_W-1:0]  cvec,
    output logic [NODES-1:0] node_mask
);

    for (genvar n = 0; n < NODES; n++) begin : g_node
        assign node_mask[n] = cvec[n / GRP];
    end

endmodule

// File: rtl/dir_entry.sv
module dir_entry
    import dirlp_pkg::*;
#(
    parameter int NODES = 16,
    parameter int NPTR  = 2,
    parameter int GRP   = 2,
    localparam int NID_W = $clog2(NODES),
    localparam int CV_W  = (NODES + GRP - 1) / GRP,
    localparam int RR_W  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [NID_W-1:0] node,
    input  logic [1:0]       policy,
    output logic             inv_flag,
    output logic [NODES-1:0] inv_mask
);

    ent_state_t                  st_q, st_n;
    logic [NPTR-1:0][NID_W-1:0]  ptr_q, ptr_n;
    logic [NPTR-1:0]             pv_q, pv_n;
    logic [CV_W-1:0]             cvec_q, cvec_n;
    logic [RR_W-1:0]             rr_q, rr_n;

    logic [NODES-1:0] coarse_mask;
    logic [NODES-1:0] exact_mask;
    logic [NODES-1:0] writer_bit;
    logic [CV_W-1:0]  ptr_groups;
    logic             hit;
    logic             have_free;
    int               free_idx;

    cvec_expand #(.NODES(NODES), .GRP(GRP)) u_expand (
        .cvec      (cvec_q),
        .node_mask (coarse_mask)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ptr_q  <= '0;
            pv_q   <= '0;
            cvec_q <= '0;
            rr_q   <= '0;
        end else begin
            st_q   <= st_n;
            ptr_q  <= ptr_n;
            pv_q   <= pv_n;
            cvec_q <= cvec_n;
            rr_q   <= rr_n;
        end
    end

    // Pointer lookup
    always_comb begin
        hit        = 1'b0;
        have_free  = 1'b0;
        free_idx   = 0;
        exact_mask = '0;
        ptr_groups = '0;
        writer_bit = '0;
        writer_bit[node] = 1'b1;
        for (int i = NPTR - 1; i >= 0; i--) begin
            if (pv_q[i]) begin
                if (ptr_q[i] == node) hit = 1'b1;
                exact_mask[ptr_q[i]] = 1'b1;
                ptr_groups[int'(ptr_q[i]) / GRP] = 1'b1;
            end else begin
                have_free = 1'b1;
                free_idx  = i;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        st_n     = st_q;
        ptr_n    = ptr_q;
        pv_n     = pv_q;
        cvec_n   = cvec_q;
        rr_n     = rr_q;
        inv_flag = 1'b0;
        inv_mask = '0;
        if (sel && wr) begin
            inv_flag = 1'b1;
            if (st_q == ST_EXACT)         inv_mask = exact_mask & ~writer_bit;
            else if (st_q == ST_OVERFLOW) inv_mask = coarse_mask & ~writer_bit;
            st_n     = ST_EXACT;
            pv_n     = '0;
            pv_n[0]  = 1'b1;
            ptr_n    = '0;
            ptr_n[0] = node;
            cvec_n   = '0;
            rr_n     = '0;
        end else if (sel) begin
            unique case (st_q)
                ST_IDLE: begin
                    ptr_n[0] = node;
                    pv_n[0]  = 1'b1;
                    st_n     = ST_EXACT;
                end
                ST_EXACT: begin
                    if (hit) begin
                        st_n = ST_EXACT;
                    end else if (have_free) begin
                        ptr_n[free_idx] = node;
                        pv_n[free_idx]  = 1'b1;
                    end else if (policy == POL_REPLACE) begin
                        inv_flag            = 1'b1;
                        inv_mask[ptr_q[rr_q]] = 1'b1;
                        ptr_n[rr_q]         = node;
                        rr_n = (rr_q == RR_W'(NPTR - 1)) ? '0 : rr_q + 1'b1;
                    end else if (policy == POL_COARSE) begin
                        cvec_n = ptr_groups;
                        cvec_n[int'(node) / GRP] = 1'b1;
                        st_n   = ST_OVERFLOW;
                    end else begin
                        cvec_n = '1;
                        st_n   = ST_OVERFLOW;
                    end
                end
                ST_OVERFLOW: begin
                    cvec_n[int'(node) / GRP] = 1'b1;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_IDLE |-> pv_q == '0); // R1

    AST_WRITE_LEAVES_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        sel && wr |=> st_q == ST_EXACT && pv_q == NPTR'(1) && ptr_q[0] == $past(node)); // R4

    AST_OVERFLOW_HAS_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_OVERFLOW |-> cvec_q != '0); // R9

    AST_EVICT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel && !wr && inv_flag |-> $countones(inv_mask) == 1); // R7

endmodule

// File: rtl/dir_lptr_top.sv
module dir_lptr_top #(
    parameter int NODES = 16,
    parameter int NPTR  = 2,
    parameter int GRP   = 2,
    parameter int NENT  = 4,
    localparam int NID_W = $clog2(NODES),
    localparam int ENT_W = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ENT_W-1:0] req_entry,
    input  logic [NID_W-1:0] req_node,
    input  logic [1:0]       policy,
    output logic             inv_valid,
    output logic [NODES-1:0] inv_mask
);

    logic [NENT-1:0]             ent_flag;
    logic [NENT-1:0][NODES-1:0]  ent_mask;
    logic                        any_flag;
    logic [NODES-1:0]            any_mask;

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        dir_entry #(.NODES(NODES), .NPTR(NPTR), .GRP(GRP)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (req_valid && (req_entry == ENT_W'(e))),
            .wr       (req_write),
            .node     (req_node),
            .policy   (policy),
            .inv_flag (ent_flag[e]),
            .inv_mask (ent_mask[e])
        );
    end

    always_comb begin
        any_flag = 1'b0;
        any_mask = '0;
        for (int e = 0; e < NENT; e++) begin
            any_flag = any_flag | ent_flag[e];
            any_mask = any_mask | ent_mask[e];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_valid <= 1'b0;
            inv_mask  <= '0;
        end else begin
            inv_valid <= any_flag;
            inv_mask  <= any_mask;
        end
    end

    AST_WRITE_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> inv_valid); // R2

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !inv_valid && inv_mask == '0); // R2

    AST_WRITER_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> inv_mask[$past(req_node)] == 1'b0); // R4

endmodule

// File: tb/dir_lptr_top_tb.sv
module dir_lptr_top_tb;

    localparam int NODES = 16;
    localparam int NPTR  = 2;
    localparam int GRP   = 2;
    localparam int NENT  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_entry = '0;
    logic [3:0]  req_node = '0;
    logic [1:0]  policy = '0;
    logic        inv_valid;
    logic [15:0] inv_mask;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    dir_lptr_top #(.NODES(NODES), .NPTR(NPTR), .GRP(GRP), .NENT(NENT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_entry (req_entry),
        .req_node  (req_node),
        .policy    (policy),
        .inv_valid (inv_valid),
        .inv_mask  (inv_mask)
    );

    task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: valid/mask got %h expected %h", req, got, exp);
        end
    endtask

    // Issue one request at a falling edge and return the report seen one cycle later.
    task automatic issue(input logic w, input int ent, input int nd, input logic [1:0] pol,
                         output logic [16:0] res);
        req_valid = 1'b1;
        req_write = w;
        req_entry = 2'(ent);
        req_node  = 4'(nd);
        policy    = pol;
        @(posedge clk);
        @(negedge clk);
        res = {inv_valid, inv_mask};
        req_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [16:0] r;
        check("R1 reset outputs", {inv_valid, inv_mask}, 17'h0);
        issue(1'b1, 3, 2, 2'b00, r);
        check("R1 write to idle entry", r, {1'b1, 16'h0000});
        @(negedge clk);
        check("R2 quiet cycle", {inv_valid, inv_mask}, 17'h0);
    endtask

    task automatic t_exact();
        logic [16:0] r;
        issue(1'b0, 3, 4, 2'b00, r);
        check("R2 read fills free pointer", r, 17'h0);
        issue(1'b0, 3, 4, 2'b00, r);
        check("R3 repeat read silent", r, 17'h0);
        issue(1'b0, 3, 2, 2'b00, r);
        check("R3 read by recorded writer silent", r, 17'h0);
        issue(1'b1, 3, 9, 2'b00, r);
        check("R4 exact write mask", r, {1'b1, 16'h0014});
        issue(1'b1, 3, 12, 2'b00, r);
        check("R4 only previous writer", r, {1'b1, 16'h0200});
        issue(1'b1, 3, 12, 2'b00, r);
        check("R4 writer excluded", r, {1'b1, 16'h0000});
    endtask

    task automatic t_bcast();
        logic [16:0] r;
        issue(1'b0, 0, 3, 2'b00, r);
        issue(1'b0, 0, 5, 2'b00, r);
        issue(1'b0, 0, 9, 2'b00, r);
        check("R6 overflow read silent", r, 17'h0);
        issue(1'b1, 0, 5, 2'b00, r);
        check("R6 broadcast write", r, {1'b1, 16'hFFDF});
        issue(1'b1, 0, 3, 2'b00, r);
        check("R11 entry 0 cleared after write", r, {1'b1, 16'h0020});
    endtask

    task automatic t_replace();
        logic [16:0] r;
        issue(1'b0, 1, 1, 2'b01, r);
        issue(1'b0, 1, 2, 2'b01, r);
        check("R2 second read silent", r, 17'h0);
        issue(1'b0, 1, 3, 2'b01, r);
        check("R7 evict slot 0", r, {1'b1, 16'h0002});
        issue(1'b0, 1, 4, 2'b01, r);
        check("R8 evict slot 1", r, {1'b1, 16'h0004});
        issue(1'b0, 1, 5, 2'b01, r);
        check("R8 index wraps to slot 0", r, {1'b1, 16'h0008});
        issue(1'b1, 1, 7, 2'b01, r);
        check("R7 write after replacements", r, {1'b1, 16'h0030});
        issue(1'b0, 1, 8, 2'b11, r);
        issue(1'b0, 1, 9, 2'b11, r);
        check("R5 alt code overflow silent", r, 17'h0);
        issue(1'b1, 1, 0, 2'b11, r);
        check("R5 alt code acts as broadcast", r, {1'b1, 16'hFFFE});
    endtask

    task automatic t_coarse();
        logic [16:0] r;
        issue(1'b0, 2, 0, 2'b10, r);
        issue(1'b0, 2, 6, 2'b10, r);
        issue(1'b0, 2, 11, 2'b10, r);
        check("R9 coarse overflow silent", r, 17'h0);
        issue(1'b0, 2, 14, 2'b10, r);
        check("R10 read in overflow silent", r, 17'h0);
        issue(1'b1, 2, 6, 2'b10, r);
        check("R9 R10 coarse write", r, {1'b1, 16'hCC83});
        issue(1'b1, 2, 1, 2'b10, r);
        check("R11 entry 2 back to exact", r, {1'b1, 16'h0040});
    endtask

    initial begin
        #(20 * 200000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_exact();
        t_bcast();
        t_replace();
        t_coarse();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule